// File: doc/BRIEF.md
# Reconfigurable Two-Bit Add/Multiply Gate Lattice

This block computes either the sum or the product of two 2-bit unsigned operands, and the same fixed set of eight reconfigurable gates does the work in both cases. Each gate is a small fixed-point nonlinear cell. It adds a per-opcode bias to its two input levels, folds the total with a tent-shaped function and subtracts a per-opcode cut. Which two-input Boolean function it computes therefore depends only on two 3-bit constants chosen by its opcode.

A single mode input changes two things: the opcode that each gate receives, and the way operand bits are steered into the first gate layer. In add mode the first-layer steered gates take the same-index bit pairs. In multiply mode they take the cross pairs. A second-layer input is re-steered in the same way. Gates pass levels directly to one another, with no decoding between stages. The 4-bit result is decoded from the final levels and registered on the next clock edge, so the chained gate path is timed as one cycle.

Top module: `morph_alu`

## Requirements
- R1: A high `rst` sampled at a rising clock edge sets `result_o` to 0 at that edge. While `rst` is high, the operands and mode have no effect on `result_o`.
- R2: `result_o` changes only at a rising edge. It reflects the `a_i`, `b_i` and `mul_i` values sampled at that edge, so a new input appears in the result one cycle after it is applied.
- R3: With `mul_i` = 0 (add), `result_o` equals `a_i + b_i` as an unsigned value. Bit 3 of the result is always 0 in this mode.
- R4: With `mul_i` = 1 (multiply), `result_o` equals the unsigned product `a_i * b_i`.
- R5: When `mul_i` differs between two consecutive cycles, each result follows only the mode sampled with its own operands, with no stale or mixed cycle.
- R6: Every gate output level is either 0 or one quarter of full scale (2 of 8 at the default width). It takes the nonzero level exactly when the gate's opcode function (AND, OR, XOR, NAND, NOR, XNOR) is true of its inputs, with each nonzero input level read as logic 1.
- R7: In add mode the steered first-layer gates see the pairs (A0,B0) and (A1,B1). In multiply mode they see (A1,B0) and (A0,B1). For example, a=01 and b=10 give 3 in add mode and 2 in multiply mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mul_i | input | 1 | Mode select: 0 = add, 1 = multiply |
| a_i | input | 2 | First operand, unsigned |
| b_i | input | 2 | Second operand, unsigned |
| result_o | output | 4 | Registered sum (zero-extended) or product |

## Verification
Assertions check every cycle that the registered result matches the sum or product of the previous cycle's operands in the mode sampled with them, and that reset clears the result. Inside each gate, they check that the tent-map arithmetic yields only the two legal levels and agrees with the Boolean truth table of its opcode. The bench scenarios are what show the timing at the ports: a result that holds until the next edge after its inputs change, back-to-back mode flips across all operand pairs, and a reset that overrides non-zero operands. The bench also drives the particular operand pairs that tell the same-index and cross routings apart.

// File: rtl/morph_pkg.sv
package morph_pkg;

  // Fixed-point level width; full scale is 2**LVL_W, logic one is a quarter of it.
  localparam int LVL_W   = 3;
  localparam int SCALE   = 1 << (LVL_W - 3);
  localparam int OP_W    = 2;
  localparam int RES_W   = 2 * OP_W;
  localparam int N_L1    = 4;
  localparam int N_L2    = 2;
  localparam int N_L3    = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_ZERO = '0;
  localparam lvl_t LVL_ONE  = lvl_t'(1) << (LVL_W - 2);

  typedef enum logic [2:0] {
    G_AND  = 3'd0,
    G_OR   = 3'd1,
    G_XOR  = 3'd2,
    G_NAND = 3'd3,
    G_NOR  = 3'd4,
    G_XNOR = 3'd5
  } gate_op_e;

  // Starting offset added to the two input levels, in eighths of full scale.
  function automatic lvl_t op_bias(gate_op_e op);
    int k;
    case (op)
      G_AND:   k = 0;
      G_OR:    k = 1;
      G_XOR:   k = 2;
      G_NAND:  k = 3;
      G_NOR:   k = 4;
      G_XNOR:  k = 6;
      default: k = 0;
    endcase
    return lvl_t'(k * SCALE);
  endfunction

  // Threshold subtracted from the folded value, in eighths of full scale.
  function automatic lvl_t op_cut(gate_op_e op);
    int k;
    case (op)
      G_AND:   k = 2;
      G_OR:    k = 1;
      G_XOR:   k = 2;
      G_NAND:  k = 1;
      G_NOR:   k = 2;
      G_XNOR:  k = 0;
      default: k = 7;
    endcase
    return lvl_t'(k * SCALE);
  endfunction

  // Plain Boolean meaning of an opcode, used only by checks.
  function automatic logic op_truth(gate_op_e op, logic x, logic y);
    case (op)
      G_AND:   return x & y;
      G_OR:    return x | y;
      G_XOR:   return x ^ y;
      G_NAND:  return ~(x & y);
      G_NOR:   return ~(x | y);
      G_XNOR:  return ~(x ^ y);
      default: return 1'b0;
    endcase
  endfunction

  function automatic lvl_t bit_to_lvl(logic b);
    return b ? LVL_ONE : LVL_ZERO;
  endfunction

endpackage

// File: rtl/tent_gate.sv
module tent_gate
  import morph_pkg::*;
(
  input  gate_op_e op_i,
  input  lvl_t     x_i,
  input  lvl_t     y_i,
  output lvl_t     z_o
);

  lvl_t bias;
  lvl_t cut;
  lvl_t acc;
  lvl_t fold;

  always_comb begin
    bias = op_bias(op_i);
    cut  = op_cut(op_i);
    // Sum wraps modulo full scale.
    acc  = bias + x_i + y_i;
    // Tent fold min(v, 1-v): upper half mirrors to the lower half.
    fold = acc[LVL_W-1] ? lvl_t'((~acc) + lvl_t'(1)) : acc;
    z_o  = (fold > cut) ? lvl_t'(fold - cut) : LVL_ZERO;
  end

  // R6: output is a legal level and matches the opcode truth table
  always_comb begin
    if ((x_i == LVL_ZERO || x_i == LVL_ONE) && (y_i == LVL_ZERO || y_i == LVL_ONE)) begin
      a_r6_level_rule: assert (z_o == (op_truth(op_i, x_i != LVL_ZERO, y_i != LVL_ZERO)
                                       ? LVL_ONE : LVL_ZERO))
        else $error("gate level does not match opcode function");
    end
  end

endmodule

// File: rtl/operand_router.sv
module operand_router
  import morph_pkg::*;
(
  input  logic            mul_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output lvl_t            x_o [N_L1],
  output lvl_t            y_o [N_L1]
);

  // Steered lanes 0 and 1; diagonal lanes 2 and 3 are fixed.
  logic [OP_W-1:0] ax;
  logic [OP_W-1:0] bx;

  always_comb begin
    case (mul_i)
      1'b0: begin
        ax = {a_i[1], a_i[0]};
        bx = {b_i[1], b_i[0]};
      end
      default: begin
        ax = {a_i[0], a_i[1]};
        bx = {b_i[1], b_i[0]};
      end
    endcase
  end

  // Lane 0: add (A0,B0), mul (A1,B0). Lane 1: add (A1,B1), mul (A0,B1).
  genvar g;
  generate
    for (g = 0; g < OP_W; g++) begin : g_steer
      assign x_o[g] = bit_to_lvl(ax[g]);
      assign y_o[g] = bit_to_lvl(bx[g]);
    end
    for (g = 0; g < OP_W; g++) begin : g_diag
      assign x_o[OP_W + g] = bit_to_lvl(a_i[g]);
      assign y_o[OP_W + g] = bit_to_lvl(b_i[g]);
    end
  endgenerate

endmodule

// File: rtl/gate_lattice.sv
module gate_lattice
  import morph_pkg::*;
(
  input  logic             mul_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [RES_W-1:0] bits_o
);

  lvl_t     l1_x [N_L1];
  lvl_t     l1_y [N_L1];
  lvl_t     l1_z [N_L1];
  gate_op_e l1_op [N_L1];

  lvl_t     l2_x [N_L2];
  lvl_t     l2_y [N_L2];
  lvl_t     l2_z [N_L2];
  gate_op_e l2_op [N_L2];

  lvl_t     l3_x [N_L3];
  lvl_t     l3_y [N_L3];
  lvl_t     l3_z [N_L3];
  gate_op_e l3_op [N_L3];

  operand_router u_router (
    .mul_i (mul_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .x_o   (l1_x),
    .y_o   (l1_y)
  );

  // Opcode program per mode.
  always_comb begin
    l1_op[0] = mul_i ? G_AND : G_XOR;
    l1_op[1] = mul_i ? G_AND : G_XOR;
    l1_op[2] = G_AND;
    l1_op[3] = G_AND;
    l2_op[0] = G_XOR;
    l2_op[1] = G_AND;
    l3_op[0] = mul_i ? G_XOR : G_OR;
    l3_op[1] = G_AND;
  end

  // Second layer: partner of lane 1 is the low carry (add) or the other cross term (mul).
  always_comb begin
    for (int i = 0; i < N_L2; i++) begin
      l2_x[i] = mul_i ? l1_z[0] : l1_z[2];
      l2_y[i] = l1_z[1];
    end
    for (int i = 0; i < N_L3; i++) begin
      l3_x[i] = l1_z[3];
      l3_y[i] = l2_z[1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_L1; g++) begin : g_l1
      tent_gate u_gate (.op_i(l1_op[g]), .x_i(l1_x[g]), .y_i(l1_y[g]), .z_o(l1_z[g]));
    end
    for (g = 0; g < N_L2; g++) begin : g_l2
      tent_gate u_gate (.op_i(l2_op[g]), .x_i(l2_x[g]), .y_i(l2_y[g]), .z_o(l2_z[g]));
    end
    for (g = 0; g < N_L3; g++) begin : g_l3
      tent_gate u_gate (.op_i(l3_op[g]), .x_i(l3_x[g]), .y_i(l3_y[g]), .z_o(l3_z[g]));
    end
  endgenerate

  // Level-to-bit decode only at the lattice boundary.
  always_comb begin
    bits_o[0] = mul_i ? (l1_z[2] != LVL_ZERO) : (l1_z[0] != LVL_ZERO);
    bits_o[1] = (l2_z[0] != LVL_ZERO);
    bits_o[2] = (l3_z[0] != LVL_ZERO);
    bits_o[3] = (l3_z[1] != LVL_ZERO);
  end

endmodule

// File: rtl/morph_alu.sv
module morph_alu
  import morph_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mul_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [RES_W-1:0] result_o
);

  logic [RES_W-1:0] lattice_bits;

  gate_lattice u_lattice (
    .mul_i  (mul_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .bits_o (lattice_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= lattice_bits;
  end

  // R1: reset clears the registered result
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> result_o == '0)
    else $error("result not cleared by reset");

  // R3: add mode gives the zero-extended sum
  a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
    !mul_i |=> result_o == (RES_W'($past(a_i)) + RES_W'($past(b_i))))
    else $error("add mode result wrong");

  // R3: add mode never sets the top bit
  a_r3_add_msb_zero: assert property (@(posedge clk) disable iff (rst)
    !mul_i |=> !result_o[RES_W-1])
    else $error("add mode top bit set");

  // R4: multiply mode gives the product
  a_r4_mul_product: assert property (@(posedge clk) disable iff (rst)
    mul_i |=> result_o == (RES_W'($past(a_i)) * RES_W'($past(b_i))))
    else $error("multiply mode result wrong");

endmodule

// File: tb/morph_alu_tb.sv
module morph_alu_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       mul;
  logic [1:0] a;
  logic [1:0] b;
  logic [3:0] result;

  int vectors = 0;
  int fails   = 0;

  morph_alu u_dut (
    .clk      (clk),
    .rst      (rst),
    .mul_i    (mul),
    .a_i      (a),
    .b_i      (b),
    .result_o (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model(logic [1:0] x, logic [1:0] y, logic m);
    int r;
    r = m ? int'(x) * int'(y) : int'(x) + int'(y);
    return 4'(r);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: a=%0d b=%0d mul=%0b actual=%0d expected=%0d",
               req, a, b, mul, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the next rising edge, check just after it.
  task automatic apply(logic [1:0] x, logic [1:0] y, logic m, string req);
    a = x; b = y; mul = m;
    @(posedge clk); #1;
    check(req, result, model(x, y, m));
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; a = 2'd3; b = 2'd3; mul = 1'b1;
    // R1: reset state with nonzero operands applied
    @(posedge clk); #1;
    check("R1", result, 4'd0);
    @(posedge clk); #1;
    check("R1", result, 4'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R4 R5 R6: every pair in both modes, mode flipping on every vector
    for (int i = 0; i < 32; i++) begin
      apply(2'(i >> 3), 2'(i >> 1), i[0], i[0] ? "R4/R5/R6" : "R3/R5/R6");
    end

    // R7: operand pairs that separate same-index from cross routing
    apply(2'b01, 2'b10, 1'b0, "R7");
    apply(2'b01, 2'b10, 1'b1, "R7");
    apply(2'b10, 2'b01, 1'b0, "R7");
    apply(2'b10, 2'b01, 1'b1, "R7");
    apply(2'b11, 2'b11, 1'b0, "R3");
    apply(2'b11, 2'b11, 1'b1, "R4");

    // R2: new inputs do not reach the result before the next edge
    apply(2'd1, 2'd1, 1'b0, "R2");
    a = 2'd3; b = 2'd3; mul = 1'b1;
    #1;
    check("R2", result, 4'd2);
    @(posedge clk); #1;
    check("R2", result, 4'd9);
    @(negedge clk);

    // R1: mid-run reset overrides operands for as long as it is held
    rst = 1'b1; a = 2'd2; b = 2'd3; mul = 1'b1;
    @(posedge clk); #1;
    check("R1", result, 4'd0);
    @(posedge clk); #1;
    check("R1", result, 4'd0);
    @(negedge clk);
    rst = 1'b0;
    apply(2'd2, 2'd3, 1'b1, "R1/R4");

    // R3 R4 R5: seeded random vectors
    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      logic [1:0] rx;
      logic [1:0] ry;
      logic       rm;
      rx = 2'($urandom);
      ry = 2'($urandom);
      rm = 1'($urandom);
      apply(rx, ry, rm, rm ? "R4/R5" : "R3/R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule